// File: doc/BRIEF.md
# Page-Table Entry Accessed/Dirty Update Controller

This block sits at the end of a page-table walk. Each time the walker has fetched a leaf page-table entry (PTE), it presents that entry for one cycle, together with the kind of access and the translation stage. The block then gives one of three outcomes. The access may go ahead. The access must take a page fault. Or the entry's accessed (A) and dirty (D) bits must first be set in memory. In the third case the block issues an atomic compare-and-swap of the modified entry and holds the request until memory answers. If the swap succeeds, the access completes. If it fails, the walker is told to restart the walk.

Whether hardware may set A/D bits, or software must be trapped to do it, is a runtime choice. It is made by an enable bit held in two 64-bit environment-configuration views: one at machine level and one at hypervisor level. The hypervisor copy cannot be on unless the machine copy is on. A build-time parameter can remove hardware A/D support entirely.

Top module: `adu_ctrl`

## Requirements
- R1: After reset both enable bits read 0, and no fault, done, restart or update request is asserted.
- R2: A write to the machine view sets its enable from bit 61 of the write data. Reads of either view return the enable in bit 61 and zero in every other bit.
- R3: A write to the hypervisor view has no effect while the machine enable is 0. Any write that leaves the machine enable at 0 also clears the hypervisor enable.
- R4: With hardware A/D support removed by parameter, both views read 0 whatever is written, and no update request is ever issued.
- R5: If the presented PTE already has A (bit 6) set, and also D (bit 7) set when the access is a store (type 1) or an AMO (type 2), then acc_done pulses on the next cycle with pte_out equal to the input, and no request is made.
- R6: If A is clear, or D is clear on a store or AMO, and the selected enable is 0, then acc_fault pulses on the next cycle and no request is made.
- R7: If an update is needed and the selected enable is 1, then upd_req rises on the next cycle with upd_cmp equal to the read PTE and upd_wdata equal to it with A set, and with D set only for a store or AMO. These values are held stable until upd_ack.
- R8: On upd_ack with upd_ok=1, acc_done pulses on the next cycle with pte_out equal to the written value and the request drops. With upd_ok=0, walk_restart pulses instead.
- R9: Stages 0 (S-mode) and 1 (G-stage) are gated by the machine enable. Stages 2 and 3 (guest first stage) are gated by the effective hypervisor enable.
- R10: pte_valid is ignored while an update request is outstanding.
- R11: A load (type 0) or fetch (type 3) never needs D, so a PTE with A set and D clear completes without a write.
- R12: At most one of acc_fault, acc_done and walk_restart is asserted in any cycle.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| cfg_wr_m | input | 1 | Write strobe for the machine-level configuration view |
| cfg_wr_h | input | 1 | Write strobe for the hypervisor-level configuration view |
| cfg_wdata | input | 64 | Configuration write data; bit 61 is the enable |
| cfg_m_rdata | output | 64 | Machine-level view read data |
| cfg_h_rdata | output | 64 | Hypervisor-level view read data |
| pte_valid | input | 1 | One-cycle strobe: a leaf PTE is presented |
| pte_in | input | 64 | Leaf PTE as read from memory |
| access_type | input | 2 | 0 load, 1 store, 2 AMO, 3 fetch |
| xlate_stage | input | 2 | 0 S-mode, 1 G-stage, 2 or 3 guest first stage |
| acc_fault | output | 1 | Pulse: raise a page fault |
| acc_done | output | 1 | Pulse: access may proceed |
| walk_restart | output | 1 | Pulse: the swap failed, so the walk must restart |
| pte_out | output | 64 | PTE to use; valid with acc_done |
| upd_req | output | 1 | Compare-and-swap request, held until upd_ack |
| upd_wdata | output | 64 | New PTE value to store |
| upd_cmp | output | 64 | Expected old PTE value |
| upd_ack | input | 1 | Memory answer strobe |
| upd_ok | input | 1 | Swap succeeded (valid with upd_ack) |

## Verification
The hardest situation to reach is a guest first-stage access whose outcome depends on hypervisor-enable state that an earlier machine-level write has silently cleared. A second hard case is a new PTE arriving while a swap is still outstanding. The directed part of the stimulus walks the enable bits through set, ignored-write and forced-clear orders, and presents a PTE in the middle of an outstanding request. A long randomized phase then mixes strobes, configuration writes and acks in the same cycles. A behavioural model is compared against every output on every clock.

// File: rtl/adu_pkg.sv
package adu_pkg;

    typedef enum logic [1:0] {
        ACC_LOAD  = 2'd0,
        ACC_STORE = 2'd1,
        ACC_AMO   = 2'd2,
        ACC_FETCH = 2'd3
    } acc_kind_e;

    typedef enum logic [1:0] {
        STG_SMODE = 2'd0,
        STG_GSTG  = 2'd1,
        STG_VS    = 2'd2,
        STG_VS_AL = 2'd3
    } xlate_stage_e;

    typedef enum logic {
        PH_IDLE = 1'b0,
        PH_WAIT = 1'b1
    } upd_phase_e;

    function automatic logic acc_writes(input logic [1:0] kind);
        return (kind == ACC_STORE) || (kind == ACC_AMO);
    endfunction

    function automatic logic stage_is_guest(input logic [1:0] stg);
        return stg[1];
    endfunction

endpackage

// File: rtl/adu_cfg_regs.sv
module adu_cfg_regs #(
    parameter int CFG_W    = 64,
    parameter int EN_POS   = 61,
    parameter bit HW_ADU   = 1'b1,
    parameter bit HAS_HYP  = 1'b1
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic             wr_m,
    input  logic             wr_h,
    input  logic [CFG_W-1:0] wdata,
    output logic             m_en,
    output logic             h_en,
    output logic [CFG_W-1:0] m_rdata,
    output logic [CFG_W-1:0] h_rdata
);

    typedef struct packed {
        logic m;
        logic h;
    } cfg_t;

    cfg_t cfg_d, cfg_q;
    logic wr_bit;

    assign wr_bit = wdata[EN_POS];

    logic unused_wdata;
    generate
        if (EN_POS == CFG_W - 1) begin : g_top_pos
            assign unused_wdata = ^wdata[EN_POS-1:0];
        end else if (EN_POS == 0) begin : g_low_pos
            assign unused_wdata = ^wdata[CFG_W-1:1];
        end else begin : g_mid_pos
            assign unused_wdata = ^{wdata[CFG_W-1:EN_POS+1], wdata[EN_POS-1:0]};
        end
    endgenerate

    always_comb begin
        cfg_d = cfg_q;
        if (wr_m) begin
            cfg_d.m = wr_bit & HW_ADU;
        end
        if (wr_h && cfg_q.m) begin
            cfg_d.h = wr_bit & HW_ADU & HAS_HYP;
        end
        if (!cfg_d.m) begin
            cfg_d.h = 1'b0;
        end
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            cfg_q <= '0;
        end else begin
            cfg_q <= cfg_d;
        end
    end

    assign m_en = cfg_q.m;
    assign h_en = cfg_q.h;

    always_comb begin
        m_rdata         = '0;
        h_rdata         = '0;
        m_rdata[EN_POS] = cfg_q.m;
        h_rdata[EN_POS] = cfg_q.h;
    end

    // R3: the hypervisor view is never on while the machine view is off
    a_r3_h_needs_m: assert property (@(posedge clk) disable iff (!rst_n)
        h_rdata[EN_POS] |-> m_rdata[EN_POS]);

    // R3: a hypervisor write while the machine view is off leaves the hypervisor view at 0
    a_r3_h_write_blocked: assert property (@(posedge clk) disable iff (!rst_n)
        (wr_h && !m_rdata[EN_POS]) |=> !h_rdata[EN_POS]);

    generate
        if (!HW_ADU) begin : g_no_hw
            // R4: without hardware support the enable always reads zero
            a_r4_no_hw_enable: assert property (@(posedge clk) disable iff (!rst_n)
                !m_rdata[EN_POS] && !h_rdata[EN_POS]);
        end
    endgenerate

endmodule

// File: rtl/adu_pte_eval.sv
module adu_pte_eval
    import adu_pkg::*;
#(
    parameter int PTE_W = 64,
    parameter int A_POS = 6,
    parameter int D_POS = 7
) (
    input  logic [PTE_W-1:0] pte,
    input  logic [1:0]       kind,
    output logic             need_upd,
    output logic [PTE_W-1:0] new_pte
);

    logic want_d;
    logic miss_a;
    logic miss_d;

    always_comb begin
        want_d   = acc_writes(kind);
        miss_a   = !pte[A_POS];
        miss_d   = want_d && !pte[D_POS];
        need_upd = miss_a || miss_d;
        new_pte  = pte;
        new_pte[A_POS] = 1'b1;
        if (want_d) begin
            new_pte[D_POS] = 1'b1;
        end
    end

endmodule

// File: rtl/adu_upd_ctrl.sv
module adu_upd_ctrl
    import adu_pkg::*;
#(
    parameter int PTE_W = 64,
    parameter int A_POS = 6
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic             pte_valid,
    input  logic [PTE_W-1:0] pte_in,
    input  logic             need_upd,
    input  logic [PTE_W-1:0] new_pte,
    input  logic             enable,
    input  logic             ack,
    input  logic             ack_ok,
    output logic             fault,
    output logic             done,
    output logic             restart,
    output logic [PTE_W-1:0] pte_out,
    output logic             req,
    output logic [PTE_W-1:0] req_wdata,
    output logic [PTE_W-1:0] req_cmp
);

    typedef struct packed {
        upd_phase_e       ph;
        logic             fault;
        logic             done;
        logic             restart;
        logic [PTE_W-1:0] pte_out;
        logic [PTE_W-1:0] wdat;
        logic [PTE_W-1:0] cmp;
    } ctl_t;

    ctl_t ctl_d, ctl_q;

    always_comb begin
        ctl_d         = ctl_q;
        ctl_d.fault   = 1'b0;
        ctl_d.done    = 1'b0;
        ctl_d.restart = 1'b0;
        unique case (ctl_q.ph)
            PH_IDLE: begin
                if (pte_valid) begin
                    if (!need_upd) begin
                        ctl_d.done    = 1'b1;
                        ctl_d.pte_out = pte_in;
                    end else if (!enable) begin
                        ctl_d.fault = 1'b1;
                    end else begin
                        ctl_d.ph   = PH_WAIT;
                        ctl_d.wdat = new_pte;
                        ctl_d.cmp  = pte_in;
                    end
                end
            end
            PH_WAIT: begin
                if (ack) begin
                    ctl_d.ph = PH_IDLE;
                    if (ack_ok) begin
                        ctl_d.done    = 1'b1;
                        ctl_d.pte_out = ctl_q.wdat;
                    end else begin
                        ctl_d.restart = 1'b1;
                    end
                end
            end
            default: ctl_d.ph = PH_IDLE;
        endcase
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            ctl_q <= '0;
        end else begin
            ctl_q <= ctl_d;
        end
    end

    assign fault     = ctl_q.fault;
    assign done      = ctl_q.done;
    assign restart   = ctl_q.restart;
    assign pte_out   = ctl_q.pte_out;
    assign req       = (ctl_q.ph == PH_WAIT);
    assign req_wdata = ctl_q.wdat;
    assign req_cmp   = ctl_q.cmp;

    // R12: at most one outcome per cycle
    a_r12_one_outcome: assert property (@(posedge clk) disable iff (!rst_n)
        $onehot0({fault, done, restart}));

    // R7: an unanswered request stays up with unchanged data
    a_r7_req_hold: assert property (@(posedge clk) disable iff (!rst_n)
        (req && !ack) |=> (req && $stable(req_wdata) && $stable(req_cmp)));

    // R7: the written value always carries A and differs from the compare value
    a_r7_wdata_sets_a: assert property (@(posedge clk) disable iff (!rst_n)
        req |-> (req_wdata[A_POS] && (req_wdata != req_cmp)));

    // R8: an answered request drops and yields done or restart
    a_r8_ack_ends: assert property (@(posedge clk) disable iff (!rst_n)
        (req && ack) |=> (!req && (done || restart)));

    // R6: a fault is never accompanied by a swap request
    a_r6_fault_no_req: assert property (@(posedge clk) disable iff (!rst_n)
        fault |-> !req);

endmodule

// File: rtl/adu_ctrl.sv
module adu_ctrl
    import adu_pkg::*;
#(
    parameter int PTE_W   = 64,
    parameter int CFG_W   = 64,
    parameter int EN_POS  = 61,
    parameter int A_POS   = 6,
    parameter int D_POS   = 7,
    parameter bit HW_ADU  = 1'b1,
    parameter bit HAS_HYP = 1'b1
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic             cfg_wr_m,
    input  logic             cfg_wr_h,
    input  logic [CFG_W-1:0] cfg_wdata,
    output logic [CFG_W-1:0] cfg_m_rdata,
    output logic [CFG_W-1:0] cfg_h_rdata,
    input  logic             pte_valid,
    input  logic [PTE_W-1:0] pte_in,
    input  logic [1:0]       access_type,
    input  logic [1:0]       xlate_stage,
    output logic             acc_fault,
    output logic             acc_done,
    output logic             walk_restart,
    output logic [PTE_W-1:0] pte_out,
    output logic             upd_req,
    output logic [PTE_W-1:0] upd_wdata,
    output logic [PTE_W-1:0] upd_cmp,
    input  logic             upd_ack,
    input  logic             upd_ok
);

    logic             m_en;
    logic             h_en;
    logic             sel_en;
    logic             need_upd;
    logic [PTE_W-1:0] new_pte;

    adu_cfg_regs #(
        .CFG_W  (CFG_W),
        .EN_POS (EN_POS),
        .HW_ADU (HW_ADU),
        .HAS_HYP(HAS_HYP)
    ) i_cfg (
        .clk    (clk),
        .rst_n  (rst_n),
        .wr_m   (cfg_wr_m),
        .wr_h   (cfg_wr_h),
        .wdata  (cfg_wdata),
        .m_en   (m_en),
        .h_en   (h_en),
        .m_rdata(cfg_m_rdata),
        .h_rdata(cfg_h_rdata)
    );

    adu_pte_eval #(
        .PTE_W(PTE_W),
        .A_POS(A_POS),
        .D_POS(D_POS)
    ) i_eval (
        .pte     (pte_in),
        .kind    (access_type),
        .need_upd(need_upd),
        .new_pte (new_pte)
    );

    assign sel_en = stage_is_guest(xlate_stage) ? h_en : m_en;

    adu_upd_ctrl #(
        .PTE_W(PTE_W),
        .A_POS(A_POS)
    ) i_upd (
        .clk      (clk),
        .rst_n    (rst_n),
        .pte_valid(pte_valid),
        .pte_in   (pte_in),
        .need_upd (need_upd),
        .new_pte  (new_pte),
        .enable   (sel_en),
        .ack      (upd_ack),
        .ack_ok   (upd_ok),
        .fault    (acc_fault),
        .done     (acc_done),
        .restart  (walk_restart),
        .pte_out  (pte_out),
        .req      (upd_req),
        .req_wdata(upd_wdata),
        .req_cmp  (upd_cmp)
    );

    // R5: a PTE needing nothing completes unchanged
    a_r5_clean_done: assert property (@(posedge clk) disable iff (!rst_n)
        (pte_valid && !upd_req && pte_in[A_POS] && (pte_in[D_POS] || !acc_writes(access_type)))
        |=> (acc_done && pte_out == $past(pte_in)));

    // R10: a strobe during an outstanding request changes nothing it carries
    a_r10_busy_ignored: assert property (@(posedge clk) disable iff (!rst_n)
        (upd_req && !upd_ack && pte_valid) |=> (upd_req && !acc_fault && !acc_done));

endmodule

// File: tb/test_adu_ctrl.sv
module test_adu_ctrl;
    import adu_pkg::*;

    localparam int EN = 61;

    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic        cfg_wr_m = 1'b0, cfg_wr_h = 1'b0;
    logic [63:0] cfg_wdata = '0;
    logic        pte_valid = 1'b0;
    logic [63:0] pte_in = '0;
    logic [1:0]  access_type = 2'd0, xlate_stage = 2'd0;
    logic        upd_ack = 1'b0, upd_ok = 1'b0;

    logic [63:0] m_rd, h_rd, pte_out, upd_wdata, upd_cmp;
    logic        acc_fault, acc_done, walk_restart, upd_req;
    logic [63:0] m_rd2, h_rd2, pte_out2, wd2, cmp2;
    logic        f2, d2, r2, req2;

    always #2 clk = ~clk;

    adu_ctrl i_adu_ctrl (
        .clk(clk), .rst_n(rst_n), .cfg_wr_m(cfg_wr_m), .cfg_wr_h(cfg_wr_h),
        .cfg_wdata(cfg_wdata), .cfg_m_rdata(m_rd), .cfg_h_rdata(h_rd),
        .pte_valid(pte_valid), .pte_in(pte_in), .access_type(access_type),
        .xlate_stage(xlate_stage), .acc_fault(acc_fault), .acc_done(acc_done),
        .walk_restart(walk_restart), .pte_out(pte_out), .upd_req(upd_req),
        .upd_wdata(upd_wdata), .upd_cmp(upd_cmp), .upd_ack(upd_ack), .upd_ok(upd_ok)
    );

    adu_ctrl #(.HW_ADU(1'b0)) i_adu_nohw (
        .clk(clk), .rst_n(rst_n), .cfg_wr_m(cfg_wr_m), .cfg_wr_h(cfg_wr_h),
        .cfg_wdata(cfg_wdata), .cfg_m_rdata(m_rd2), .cfg_h_rdata(h_rd2),
        .pte_valid(pte_valid), .pte_in(pte_in), .access_type(access_type),
        .xlate_stage(xlate_stage), .acc_fault(f2), .acc_done(d2),
        .walk_restart(r2), .pte_out(pte_out2), .upd_req(req2),
        .upd_wdata(wd2), .upd_cmp(cmp2), .upd_ack(upd_ack), .upd_ok(upd_ok)
    );

    int    n_tests = 0;
    int    n_fail  = 0;
    string tag = "R1";
    bit    running = 1'b0;

    // behavioural reference
    bit          md_m, md_h, md_busy;
    bit [63:0]   md_w, md_c, e_pte;
    bit          e_fault, e_done, e_rst;

    always @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            md_m = 0; md_h = 0; md_busy = 0; e_fault = 0; e_done = 0; e_rst = 0;
        end else begin
            bit nm, nh, en, need_a, need_d, st;
            e_fault = 0; e_done = 0; e_rst = 0;
            if (md_busy) begin
                if (upd_ack) begin
                    md_busy = 0;
                    if (upd_ok) begin e_done = 1; e_pte = md_w; end
                    else e_rst = 1;
                end
            end else if (pte_valid) begin
                st     = (access_type == 2'd1) || (access_type == 2'd2);
                en     = xlate_stage[1] ? md_h : md_m;
                need_a = !pte_in[6];
                need_d = st && !pte_in[7];
                if (!need_a && !need_d) begin e_done = 1; e_pte = pte_in; end
                else if (!en) e_fault = 1;
                else begin
                    md_busy = 1; md_c = pte_in;
                    md_w = pte_in | 64'h40 | (st ? 64'h80 : 64'h0);
                end
            end
            nm = cfg_wr_m ? cfg_wdata[EN] : md_m;
            nh = (cfg_wr_h && md_m) ? cfg_wdata[EN] : md_h;
            if (!nm) nh = 0;
            md_m = nm; md_h = nh;
        end
    end

    task automatic chk(input bit ok, input string what, input logic [63:0] act, input logic [63:0] exp);
        n_tests++;
        if (!ok) begin
            n_fail++;
            $display("FAIL %s %s actual=%h expected=%h", tag, what, act, exp);
        end
    endtask

    always @(negedge clk) begin
        if (running) begin
            chk(acc_fault == e_fault, "fault", 64'(acc_fault), 64'(e_fault));
            chk(acc_done == e_done, "done", 64'(acc_done), 64'(e_done));
            chk(walk_restart == e_rst, "restart", 64'(walk_restart), 64'(e_rst));
            chk(upd_req == md_busy, "req", 64'(upd_req), 64'(md_busy));
            if (e_done) chk(pte_out == e_pte, "pte_out", pte_out, e_pte);
            if (md_busy) begin
                chk(upd_wdata == md_w, "wdata", upd_wdata, md_w);
                chk(upd_cmp == md_c, "cmp", upd_cmp, md_c);
            end
            chk(m_rd == (64'(md_m) << EN), "m view", m_rd, 64'(md_m) << EN);
            chk(h_rd == (64'(md_h) << EN), "h view", h_rd, 64'(md_h) << EN);
            // R4: the instance without hardware support
            chk(m_rd2 == 64'h0 && h_rd2 == 64'h0, "R4 views", m_rd2 | h_rd2, 64'h0);
            chk(!req2, "R4 no request", 64'(req2), 64'h0);
        end
    end

    task automatic wait_n(input int n);
        for (int i = 0; i < n; i++) @(negedge clk);
    endtask

    task automatic present(input logic [63:0] p, input logic [1:0] k, input logic [1:0] s);
        @(negedge clk);
        pte_valid = 1; pte_in = p; access_type = k; xlate_stage = s;
        @(negedge clk);
        pte_valid = 0;
    endtask

    task automatic wcfg(input bit to_h, input bit v);
        @(negedge clk);
        cfg_wr_m = !to_h; cfg_wr_h = to_h; cfg_wdata = 64'(v) << EN;
        @(negedge clk);
        cfg_wr_m = 0; cfg_wr_h = 0; cfg_wdata = '0;
    endtask

    task automatic answer(input bit ok);
        @(negedge clk);
        upd_ack = 1; upd_ok = ok;
        @(negedge clk);
        upd_ack = 0; upd_ok = 0;
    endtask

    initial begin
        int cyc = 0;
        while (cyc < 150000) begin @(posedge clk); cyc++; end
        n_tests++; n_fail++;
        $display("FAIL watchdog expired actual=%0d expected<%0d", cyc, 150000);
        $display("[TB] %0d tests run, %0d failed", n_tests, n_fail);
        $finish;
    end

    initial begin
        wait_n(3);
        rst_n = 1;
        running = 1;
        tag = "R1"; wait_n(3);

        tag = "R6"; present(64'h1000_0001, 2'd0, 2'd0); wait_n(1);
        present(64'h41, 2'd1, 2'd0); wait_n(1);
        present(64'h41, 2'd2, 2'd1); wait_n(1);
        tag = "R11"; present(64'h41, 2'd0, 2'd0); present(64'h45, 2'd3, 2'd2); wait_n(1);
        tag = "R5"; present(64'hC1, 2'd1, 2'd0); present(64'hC1, 2'd2, 2'd2); wait_n(1);

        tag = "R3"; wcfg(1, 1); wait_n(1);
        tag = "R2"; @(negedge clk); cfg_wr_m = 1; cfg_wdata = '1; @(negedge clk); cfg_wr_m = 0; cfg_wdata = '0;
        wait_n(1);
        tag = "R7"; present(64'h0000_0001, 2'd0, 2'd0); wait_n(2);
        tag = "R8"; answer(1); wait_n(1);
        tag = "R7"; present(64'h1, 2'd1, 2'd1); wait_n(1);
        tag = "R10"; present(64'hC1, 2'd0, 2'd0); present(64'h1, 2'd2, 2'd0);
        tag = "R8"; answer(0); wait_n(1);
        tag = "R8"; @(negedge clk); pte_valid = 1; pte_in = 64'h81; access_type = 2'd2; xlate_stage = 2'd0;
        @(negedge clk); pte_valid = 0; upd_ack = 1; upd_ok = 1;
        @(negedge clk); upd_ack = 0; upd_ok = 0; wait_n(1);

        tag = "R9"; present(64'h1, 2'd0, 2'd2); wait_n(1);
        wcfg(1, 1); present(64'h1, 2'd0, 2'd3); wait_n(1); answer(1); wait_n(1);
        tag = "R3"; wcfg(0, 0); wait_n(1); wcfg(0, 1); wait_n(1);
        tag = "R9"; present(64'h1, 2'd1, 2'd2); present(64'h1, 2'd1, 2'd1); wait_n(2);

        tag = "R12";
        for (int i = 0; i < 3000; i++) begin
            @(negedge clk);
            pte_valid   = ($urandom % 3) == 0;
            pte_in      = {$urandom, $urandom};
            access_type = 2'($urandom);
            xlate_stage = 2'($urandom);
            upd_ack     = ($urandom % 4) == 0;
            upd_ok      = ($urandom % 3) != 0;
            cfg_wr_m    = ($urandom % 16) == 0;
            cfg_wr_h    = ($urandom % 8) == 0;
            cfg_wdata   = {$urandom, $urandom};
        end
        @(negedge clk);
        pte_valid = 0; upd_ack = 1; upd_ok = 1; cfg_wr_m = 0; cfg_wr_h = 0;
        @(negedge clk); upd_ack = 0;
        wait_n(3);
        running = 0;
        $display("[TB] %0d tests run, %0d failed", n_tests, n_fail);
        $finish;
    end

endmodule